// File: doc/BRIEF.md
# Byte-Parallel CRC-8 Register Peripheral

This block is a small memory-mapped CRC-8 engine. It sits behind a 16-bit register word that has two byte lanes. The low lane is the data lane. Every byte written there is folded into the running checksum in one clock. The fold uses the fixed generator x^8 + x^2 + x + 1 (0x07) and gives the same result as eight steps of a serial shift register. The high lane is the control lane. It holds two reflection options and a self-clearing restart bit.

Software uses the block in a loop. It restarts the checksum, writes the message bytes one after another, reads the result, and then restarts for the next message. Input reflection reverses each byte before it is folded in, so least-significant-bit-first data can be handled. Output reflection reverses the result only on the read path. The stored state never changes because of it.

Top module: `crc8_periph`

## Requirements
- R1: After reset, `rd_data` reads 0x0000. The checksum is 0x00 and both reflection options are clear.
- R2: The read word is laid out as follows. Bits 7:0 hold the checksum as presented by the output stage. Bit 8 is the input-reflect option. Bit 9 is the output-reflect option. Bit 10 is the restart bit, which always reads 0. Bits 15:11 read 0.
- R3: A write with `wr_en` high and `wr_be[0]` high folds `wr_data[7:0]` into the checksum with generator 0x07. Byte bit 7 is processed first. The result equals eight serial shift-register steps and is visible on `rd_data` after the write's clock edge.
- R4: When the input-reflect option (bit 8) is 1, each written byte is bit-reversed before it is folded in.
- R5: When the output-reflect option (bit 9) is 1, bits 7:0 read as the bit-reversed checksum. Changing this option never alters the stored checksum, so toggling it in the middle of a message leaves the final result intact.
- R6: A control-lane write (`wr_be[1]` high) with bit 10 set reloads the checksum to 0x00 at that clock edge. The bit does not stay set.
- R7: When a data byte and a restart are written in the same word, the restart wins and the byte is discarded.
- R8: If the reflection options are written in the same word as a data byte, that byte is folded using the options held before the write. The new options apply from the next byte on.
- R9: A cycle with `wr_en` low, or a write with a lane's enable low, leaves that lane's state unchanged.
- R10: Starting from 0x00 with no reflection, the ASCII message "123456789" yields 0xF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register word |
| wr_be | input | 2 | Lane enables: bit 0 for the data lane, bit 1 for the control lane |
| wr_data | input | 16 | Write word: data byte in 7:0, control byte in 15:8 |
| rd_data | output | 16 | Read word: presented checksum and control state |

## Verification
The hardest cases to reach are the ones where both lanes change in the same write. Examples are a restart arriving together with a byte, or new reflection options arriving together with a byte. In these cases the ordering rules decide the result. The stimulus issues full-word writes that set both lane enables, and then keeps streaming bytes. A wrong choice of which wins, or of which options were in force, therefore shows up in the checksums that follow. The bench also toggles output reflection halfway through a message. It then compares every readback against a bit-serial model that keeps the running state separate from the presented value.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int          CRC_W      = 8;
    localparam logic [7:0]  CRC_POLY   = 8'h07;
    localparam logic [7:0]  CRC_SEED   = 8'h00;

    localparam int          LANE_W     = 8;
    localparam int          LANES      = 2;
    localparam int          BUS_W      = LANE_W * LANES;

    localparam int          DATA_LANE  = 0;
    localparam int          CTRL_LANE  = 1;

    localparam int          RIN_BIT    = 0;
    localparam int          ROUT_BIT   = 1;
    localparam int          RESTART_BIT = 2;

    typedef struct packed {
        logic refl_out;
        logic refl_in;
    } crc_opts_t;

    typedef struct packed {
        logic              restart;
        logic              load;
        logic [CRC_W-1:0]  byte_in;
    } crc_cmd_t;

    function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    // Image of a lone 1 at position j of (state ^ byte) after one whole byte.
    function automatic logic [CRC_W-1:0] fold_column(input int j);
        logic [CRC_W-1:0] s;
        logic             top;
        s = '0;
        s[j] = 1'b1;
        for (int k = 0; k < CRC_W; k++) begin
            top = s[CRC_W-1];
            s   = {s[CRC_W-2:0], 1'b0} ^ (top ? CRC_POLY : '0);
        end
        return s;
    endfunction

    // Which bits of (state ^ byte) feed result bit b.
    function automatic logic [CRC_W-1:0] fold_row(input int b);
        logic [CRC_W-1:0] m;
        logic [CRC_W-1:0] c;
        for (int j = 0; j < CRC_W; j++) begin
            c    = fold_column(j);
            m[j] = c[b];
        end
        return m;
    endfunction

endpackage

// File: rtl/crc8_opts_reg.sv
module crc8_opts_reg
    import crc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [LANE_W-1:0] ctrl_byte,
    output crc_opts_t         opts,
    output logic              restart_req
);

    crc_opts_t opts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opts_q <= '0;
        end else if (ctrl_we) begin
            opts_q.refl_in  <= ctrl_byte[RIN_BIT];
            opts_q.refl_out <= ctrl_byte[ROUT_BIT];
        end
    end

    assign opts        = opts_q;
    assign restart_req = ctrl_we & ctrl_byte[RESTART_BIT];

    // R1
    opts_reset_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> opts_q == '0);

    // R9
    opts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(opts_q));

endmodule

// File: rtl/crc8_engine.sv
module crc8_engine
    import crc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  crc_cmd_t          cmd,
    input  logic              refl_in,
    output logic [CRC_W-1:0]  crc_q
);

    logic [CRC_W-1:0] ordered;
    logic [CRC_W-1:0] mixed;
    logic [CRC_W-1:0] folded;
    logic [CRC_W-1:0] state_q;

    for (genvar i = 0; i < CRC_W; i++) begin : g_order
        assign ordered[i] = refl_in ? cmd.byte_in[CRC_W-1-i] : cmd.byte_in[i];
    end

    assign mixed = state_q ^ ordered;

    for (genvar b = 0; b < CRC_W; b++) begin : g_fold
        localparam logic [CRC_W-1:0] ROW = fold_row(b);
        assign folded[b] = ^(mixed & ROW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CRC_SEED;
        end else if (cmd.restart) begin
            state_q <= CRC_SEED;
        end else if (cmd.load) begin
            state_q <= folded;
        end
    end

    assign crc_q = state_q;

    // R6 R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.restart |=> state_q == CRC_SEED);

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd.restart && !cmd.load |=> $stable(state_q));

endmodule

// File: rtl/crc8_present.sv
module crc8_present
    import crc8_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic             refl_out,
    output logic [CRC_W-1:0] crc_out
);

    always_comb begin
        crc_out = refl_out ? bit_rev(crc_in) : crc_in;
    end

    // R5
    always_comb begin
        present_weight_chk: assert ($countones(crc_out) == $countones(crc_in));
    end

endmodule

// File: rtl/crc8_periph.sv
module crc8_periph
    import crc8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data
);

    localparam int PAD_W = LANE_W - 3;

    logic              data_we;
    logic              ctrl_we;
    crc_opts_t         opts;
    logic              restart_req;
    crc_cmd_t          cmd;
    logic [CRC_W-1:0]  crc_state;
    logic [CRC_W-1:0]  crc_shown;

    assign data_we = wr_en & wr_be[DATA_LANE];
    assign ctrl_we = wr_en & wr_be[CTRL_LANE];

    crc8_opts_reg u_opts (
        .clk         (clk),
        .rst         (rst),
        .ctrl_we     (ctrl_we),
        .ctrl_byte   (wr_data[CTRL_LANE*LANE_W +: LANE_W]),
        .opts        (opts),
        .restart_req (restart_req)
    );

    always_comb begin
        cmd.restart = restart_req;
        cmd.load    = data_we & ~restart_req;
        cmd.byte_in = wr_data[DATA_LANE*LANE_W +: LANE_W];
    end

    crc8_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .refl_in (opts.refl_in),
        .crc_q   (crc_state)
    );

    crc8_present u_present (
        .crc_in   (crc_state),
        .refl_out (opts.refl_out),
        .crc_out  (crc_shown)
    );

    assign rd_data = {{PAD_W{1'b0}}, 1'b0, opts.refl_out, opts.refl_in, crc_shown};

    // R5
    ctrl_only_keeps_crc_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_be == 2'b10 && !wr_data[LANE_W + RESTART_BIT] |=> $stable(crc_state));

    // R2
    always_comb begin
        rd_pad_chk: assert (rst || rd_data[15:10] == '0);
    end

endmodule

// File: tb/crc8_periph_test.sv
module crc8_periph_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    crc8_periph uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    typedef struct {
        string       req;
        logic [15:0] exp;
    } sb_item_t;

    sb_item_t sbq[$];

    logic [7:0] m_crc;
    logic       m_rin;
    logic       m_rout;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [7:0] serial_fold(input logic [7:0] c, input logic [7:0] b);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ b[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [15:0] model_word();
        return {5'b0, 1'b0, m_rout, m_rin, (m_rout ? rev8(m_crc) : m_crc)};
    endfunction

    task automatic push(input string req);
        sb_item_t it;
        it.req = req;
        it.exp = model_word();
        sbq.push_back(it);
    endtask

    task automatic bus_write(input logic en, input logic [1:0] be,
                             input logic [15:0] d, input string req);
        @(negedge clk);
        wr_en   = en;
        wr_be   = be;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en) begin
            logic [7:0] b;
            logic       restart;
            b       = m_rin ? rev8(d[7:0]) : d[7:0];
            restart = be[1] && d[10];
            if (restart) m_crc = 8'h00;
            else if (be[0]) m_crc = serial_fold(m_crc, b);
            if (be[1]) begin
                m_rin  = d[8];
                m_rout = d[9];
            end
        end
        push(req);
    endtask

    task automatic set_opts(input logic rin, input logic rout, input logic restart,
                            input string req);
        bus_write(1'b1, 2'b10, {5'b0, restart, rout, rin, 8'h00}, req);
    endtask

    task automatic put_byte(input logic [7:0] b, input string req);
        bus_write(1'b1, 2'b01, {8'h00, b}, req);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!done && sbq.size() != 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s rd_data=%h expected=%h", it.req, rd_data, it.exp);
            end
        end
    end

    task automatic send_msg(input logic rin, input logic rout, input string req);
        string s;
        s = "123456789";
        set_opts(rin, rout, 1'b1, req);
        for (int i = 0; i < s.len(); i++) put_byte(s[i], req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0000;
        m_crc = 8'h00; m_rin = 1'b0; m_rout = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        @(posedge clk); #1 push("R1 reset");
        drain();

        // R3 R10 known vector, no reflection
        send_msg(1'b0, 1'b0, "R3 R10 check string");
        drain();
        checks++;
        if (rd_data[7:0] !== 8'hF4) begin
            errors++;
            $display("FAIL R10 crc=%h expected=f4", rd_data[7:0]);
        end

        // R4 R5 R2 all four reflection combinations
        send_msg(1'b1, 1'b0, "R4 reflect in");
        send_msg(1'b0, 1'b1, "R5 reflect out");
        send_msg(1'b1, 1'b1, "R2 R4 R5 both reflections");
        drain();

        // R6 zero-byte message: restart then read
        set_opts(1'b0, 1'b0, 1'b1, "R6 restart empty message");
        put_byte(8'h80, "R3 single bit byte");
        put_byte(8'h01, "R3 low bit byte");
        put_byte(8'hFF, "R3 all ones byte");

        // R5 toggle output reflection mid-message
        set_opts(1'b0, 1'b1, 1'b0, "R5 toggle out on");
        put_byte(8'h5A, "R5 byte under out reflect");
        set_opts(1'b0, 1'b0, 1'b0, "R5 toggle out off");
        put_byte(8'hC3, "R5 byte after toggle");

        // R7 restart and byte together
        bus_write(1'b1, 2'b11, {5'b0, 1'b1, 2'b00, 8'hA5}, "R7 restart beats byte");
        put_byte(8'h3C, "R7 stream after restart");

        // R8 options change with byte in same word
        bus_write(1'b1, 2'b11, {5'b0, 1'b0, 1'b0, 1'b1, 8'h0F}, "R8 old rin applies");
        put_byte(8'h0F, "R8 new rin applies");
        bus_write(1'b1, 2'b11, {5'b0, 1'b0, 1'b1, 1'b0, 8'hE1}, "R8 rin cleared rout set");

        // R9 ignored writes
        bus_write(1'b0, 2'b11, {5'b0, 1'b1, 1'b1, 1'b1, 8'h77}, "R9 wr_en low");
        bus_write(1'b1, 2'b00, {5'b0, 1'b1, 1'b0, 1'b1, 8'h77}, "R9 no lanes");
        bus_write(1'b1, 2'b10, {8'h00, 8'h99}, "R9 data lane off");
        put_byte(8'h12, "R9 ctrl lane off");

        // R6 restart bit reads zero, final restart
        set_opts(1'b1, 1'b1, 1'b1, "R6 restart with options");
        for (int k = 0; k < 16; k++) put_byte(8'(k * 37 + 11), "R3 R4 R5 sweep");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule